// File: doc/BRIEF.md
# Flash Command Sequence Decoder

This block sits on the device side of a parallel NOR flash model. It watches single-cycle bus writes, each an address and a data byte, and finds the unlock-prefixed command sequences in them. Two sequences are recognised. The first is a four-write program command, which raises a one-cycle request carrying the target address and data for an embedded program engine. The second is a six-write sector erase, which opens a sector-load window and records the selected sector in a bitmap.

While the load window is open, more sector-load writes can be added, and each one restarts the window. When the window runs out with no further write, the erase starts. The erase itself is modelled by a cycle counter. A suspend command halts the erase, either at once if it arrives during the load window or after a fixed latency if the erase is running. While the erase is suspended, sectors outside the bitmap can still be programmed. A resume command continues the erase with the progress it had already made.

The unlock writes and the command bytes are fixed. The sector is taken from the top `SECT_W` bits of the address. All time windows are counted in clock cycles and set by parameters.

Top module: `flash_cmd_decoder`

## Requirements
- R1: After reset, `mode` is 0 (read), `sect_sel` is 0, and `prog_start`, `erase_start` and `load_open` are low. The `mode` encoding is 0 = read, 1 = erase (this includes the load window), 2 = suspended, 3 = suspended-program. In every cycle, `mode` is 0 exactly when `sect_sel` is 0.
- R2: In read mode, the four writes (555h, AAh), (2AAh, 55h), (555h, A0h), (A, D) raise `prog_start` for exactly one cycle, in the cycle after the fourth write, with `prog_addr` = A and `prog_data` = D. `mode` stays 0. Unlock addresses are compared on address bits [10:0].
- R3: If any unlock or set-up write carries the wrong address or the wrong data, the sequence is dropped with no request, and the next write is decoded as the start of a new sequence.
- R4: In read mode, the writes (555h, AAh), (2AAh, 55h), (555h, 80h), (555h, AAh), (2AAh, 55h), (S, 30h) set `sect_sel` to a one-hot value for the sector in S[ADDR_W-1 -: SECT_W]. In the next cycle `load_open` is 1 and `mode` is 1.
- R5: While `load_open` is 1, a write of 30h ORs its sector into `sect_sel` and restarts the window. A write on any of the `WIN_CYC` edges after the previous load write is accepted. A 30h written after the window has closed changes nothing.
- R6: If none of the `WIN_CYC` edges after the last load write carries a write, `load_open` falls on the last of those edges and `erase_start` pulses for one cycle. `mode` then stays 1 for `ERASE_CYC` cycles and returns to 0, with `sect_sel` cleared.
- R7: While `load_open` is 1, any write whose data is neither 30h nor B0h returns `mode` to 0, clears `sect_sel` and closes the window.
- R8: A B0h write while `load_open` is 1 sets `mode` to 2 in the next cycle and clears `load_open`.
- R9: A B0h write during an active erase sets `mode` to 2 after `SUSP_LAT` cycles. The erase keeps running during this latency and is frozen while suspended.
- R10: A 30h write in mode 2 resumes the erase. `mode` becomes 1, `erase_start` pulses, and only the erase cycles that remain are run.
- R11: B0h has no effect outside an erase. 30h has no effect outside the suspended state.
- R12: In mode 2, a program to a sector not set in `sect_sel` raises `prog_start` and holds `mode` at 3 for `PROG_CYC` cycles, then returns to 2. A program to a selected sector, or a full erase sequence, leaves `mode` and `sect_sel` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Bus write strobe, one cycle per write |
| wr_addr | input | ADDR_W | Write address |
| wr_data | input | 8 | Write data byte |
| prog_start | output | 1 | One-cycle program request |
| prog_addr | output | ADDR_W | Program target address |
| prog_data | output | 8 | Program data |
| erase_start | output | 1 | One-cycle erase run request (window close or resume) |
| sect_sel | output | 2**SECT_W | Bitmap of selected sectors |
| load_open | output | 1 | Sector-load window open |
| mode | output | 2 | 0 read, 1 erase, 2 suspended, 3 suspended-program |

## Verification
Some properties are checked by assertions on every cycle. These are the tie between the mode and the sector bitmap, the rule that an erase start or an open window appears only in erase mode, the single-cycle program pulse, and the rules for entering suspended-program mode and which sectors it may target. Exact cycle counts can only be shown by the bench scenarios, which count cycles against the short parameters. These counts cover the last accepted edge of the load window, the suspend latency, the number of erase cycles left after a resume, and the length of a suspended program. The bench scenarios also show that commands are ignored or dropped in the wrong states.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;
  typedef enum logic [1:0] {
    MODE_READ  = 2'd0,
    MODE_ERASE = 2'd1,
    MODE_SUSP  = 2'd2,
    MODE_SPROG = 2'd3
  } mode_t;

  typedef enum logic [2:0] {
    CT_READ, CT_LOAD, CT_ERASE, CT_SPEND, CT_SUSP, CT_SPROG
  } ctl_t;

  localparam logic [7:0]  CMD_KEY_A   = 8'hAA;
  localparam logic [7:0]  CMD_KEY_B   = 8'h55;
  localparam logic [7:0]  CMD_PROG    = 8'hA0;
  localparam logic [7:0]  CMD_ERSETUP = 8'h80;
  localparam logic [7:0]  CMD_SECTOR  = 8'h30;
  localparam logic [7:0]  CMD_HALT    = 8'hB0;
  localparam logic [10:0] ADR_KEY_A   = 11'h555;
  localparam logic [10:0] ADR_KEY_B   = 11'h2AA;

  function automatic mode_t mode_of(ctl_t c);
    case (c)
      CT_READ:  return MODE_READ;
      CT_SUSP:  return MODE_SUSP;
      CT_SPROG: return MODE_SPROG;
      default:  return MODE_ERASE;
    endcase
  endfunction
endpackage

// File: rtl/fcd_down.sv
module fcd_down #(
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  input  logic          dec,
  output logic          at_one
);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)                      cnt <= '0;
    else if (load)                cnt <= load_val;
    else if (dec && cnt != '0)    cnt <= cnt - 1'b1;
  end

  assign at_one = (cnt == CW'(1));
endmodule

// File: rtl/fcd_seq.sv
module fcd_seq
  import flash_cmd_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        en,
  input  logic        allow_erase,
  input  logic        wr_en,
  input  logic [10:0] wr_lo,
  input  logic [7:0]  wr_data,
  output logic        prog_ev,
  output logic        erase_ev,
  output logic        idle
);
  typedef enum logic [2:0] {S_IDLE, S_K1, S_K2, S_PSET, S_ESET, S_EK1, S_EK2} seq_t;
  seq_t st, st_n;

  logic key_a, key_b;
  assign key_a = (wr_lo == ADR_KEY_A) && (wr_data == CMD_KEY_A);
  assign key_b = (wr_lo == ADR_KEY_B) && (wr_data == CMD_KEY_B);

  always_comb begin
    st_n     = st;
    prog_ev  = 1'b0;
    erase_ev = 1'b0;
    if (!en) begin
      st_n = S_IDLE;
    end else if (wr_en) begin
      st_n = S_IDLE;
      case (st)
        S_IDLE: if (key_a) st_n = S_K1;
        S_K1:   if (key_b) st_n = S_K2;
        S_K2: begin
          if (wr_lo == ADR_KEY_A && wr_data == CMD_PROG) st_n = S_PSET;
          else if (allow_erase && wr_lo == ADR_KEY_A && wr_data == CMD_ERSETUP) st_n = S_ESET;
        end
        S_PSET: prog_ev = 1'b1;
        S_ESET: if (key_a) st_n = S_EK1;
        S_EK1:  if (key_b) st_n = S_EK2;
        S_EK2:  erase_ev = (wr_data == CMD_SECTOR);
        default: st_n = S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) st <= S_IDLE;
    else     st <= st_n;
  end

  assign idle = (st == S_IDLE);

  // R4: an erase event only follows the erase set-up path
  a_r4_erase_path: assert property (@(posedge clk) disable iff (rst)
    erase_ev |-> $past(allow_erase));
endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder
  import flash_cmd_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int SECT_W    = 3,
  parameter int WIN_CYC   = 6250,
  parameter int ERASE_CYC = 100000,
  parameter int SUSP_LAT  = 2500,
  parameter int PROG_CYC  = 1000
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 wr_en,
  input  logic [ADDR_W-1:0]    wr_addr,
  input  logic [7:0]           wr_data,
  output logic                 prog_start,
  output logic [ADDR_W-1:0]    prog_addr,
  output logic [7:0]           prog_data,
  output logic                 erase_start,
  output logic [2**SECT_W-1:0] sect_sel,
  output logic                 load_open,
  output logic [1:0]           mode
);
  localparam int NSECT = 2**SECT_W;
  localparam int MAX_A = (WIN_CYC > ERASE_CYC) ? WIN_CYC : ERASE_CYC;
  localparam int MAX_B = (SUSP_LAT > PROG_CYC) ? SUSP_LAT : PROG_CYC;
  localparam int MAX_C = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int CNT_W = $clog2(MAX_C + 1);

  ctl_t  ctl, ctl_n;
  mode_t mode_q;
  logic [NSECT-1:0]  sel_n, sect_bit;
  logic [SECT_W-1:0] wr_sect;
  logic              ps_n, es_n;
  logic [ADDR_W-1:0] pa_n;
  logic [7:0]        pd_n;
  logic              win_ld, ers_ld, aux_ld;
  logic [CNT_W-1:0]  aux_val;
  logic              win_one, ers_one, aux_one;
  logic              prog_ev, erase_ev, seq_idle;

  assign wr_sect  = wr_addr[ADDR_W-1 -: SECT_W];
  assign sect_bit = NSECT'(1) << wr_sect;

  fcd_seq u_seq (
    .clk(clk), .rst(rst),
    .en(ctl == CT_READ || ctl == CT_SUSP),
    .allow_erase(ctl == CT_READ),
    .wr_en(wr_en), .wr_lo(wr_addr[10:0]), .wr_data(wr_data),
    .prog_ev(prog_ev), .erase_ev(erase_ev), .idle(seq_idle)
  );

  fcd_down #(.CW(CNT_W)) u_win (
    .clk(clk), .rst(rst), .load(win_ld), .load_val(CNT_W'(WIN_CYC)),
    .dec(ctl == CT_LOAD && !wr_en), .at_one(win_one)
  );

  fcd_down #(.CW(CNT_W)) u_ers (
    .clk(clk), .rst(rst), .load(ers_ld), .load_val(CNT_W'(ERASE_CYC)),
    .dec(ctl == CT_ERASE || ctl == CT_SPEND), .at_one(ers_one)
  );

  fcd_down #(.CW(CNT_W)) u_aux (
    .clk(clk), .rst(rst), .load(aux_ld), .load_val(aux_val),
    .dec(ctl == CT_SPEND || ctl == CT_SPROG), .at_one(aux_one)
  );

  always_comb begin
    ctl_n   = ctl;
    sel_n   = sect_sel;
    ps_n    = 1'b0;
    es_n    = 1'b0;
    pa_n    = prog_addr;
    pd_n    = prog_data;
    win_ld  = 1'b0;
    ers_ld  = 1'b0;
    aux_ld  = 1'b0;
    aux_val = CNT_W'(SUSP_LAT);
    case (ctl)
      CT_READ: begin
        if (prog_ev) begin
          ps_n = 1'b1; pa_n = wr_addr; pd_n = wr_data;
        end else if (erase_ev) begin
          ctl_n = CT_LOAD; sel_n = sect_bit; win_ld = 1'b1;
        end
      end
      CT_LOAD: begin
        if (wr_en) begin
          if (wr_data == CMD_SECTOR) begin
            sel_n = sect_sel | sect_bit; win_ld = 1'b1;
          end else if (wr_data == CMD_HALT) begin
            ctl_n = CT_SUSP; ers_ld = 1'b1;
          end else begin
            ctl_n = CT_READ; sel_n = '0;
          end
        end else if (win_one) begin
          ctl_n = CT_ERASE; es_n = 1'b1; ers_ld = 1'b1;
        end
      end
      CT_ERASE: begin
        if (ers_one) begin
          ctl_n = CT_READ; sel_n = '0;
        end else if (wr_en && wr_data == CMD_HALT) begin
          ctl_n = CT_SPEND; aux_ld = 1'b1;
        end
      end
      CT_SPEND: begin
        if (ers_one) begin
          ctl_n = CT_READ; sel_n = '0;
        end else if (aux_one) begin
          ctl_n = CT_SUSP;
        end
      end
      CT_SUSP: begin
        if (prog_ev) begin
          if ((sect_sel & sect_bit) == '0) begin
            ctl_n = CT_SPROG; ps_n = 1'b1; pa_n = wr_addr; pd_n = wr_data;
            aux_ld = 1'b1; aux_val = CNT_W'(PROG_CYC);
          end
        end else if (wr_en && seq_idle && wr_data == CMD_SECTOR) begin
          ctl_n = CT_ERASE; es_n = 1'b1;
        end
      end
      CT_SPROG: if (aux_one) ctl_n = CT_SUSP;
      default: ctl_n = CT_READ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl         <= CT_READ;
      mode_q      <= MODE_READ;
      sect_sel    <= '0;
      prog_start  <= 1'b0;
      prog_addr   <= '0;
      prog_data   <= '0;
      erase_start <= 1'b0;
      load_open   <= 1'b0;
    end else begin
      ctl         <= ctl_n;
      mode_q      <= mode_of(ctl_n);
      sect_sel    <= sel_n;
      prog_start  <= ps_n;
      prog_addr   <= pa_n;
      prog_data   <= pd_n;
      erase_start <= es_n;
      load_open   <= (ctl_n == CT_LOAD);
    end
  end

  assign mode = mode_q;

  // R1: bitmap is empty exactly in read mode
  a_r1_sel_vs_mode: assert property (@(posedge clk) disable iff (rst)
    (mode == MODE_READ) == (sect_sel == '0));
  // R2: program request lasts one cycle
  a_r2_single_pulse: assert property (@(posedge clk) disable iff (rst)
    prog_start |=> !prog_start);
  // R4: open window only seen in erase mode
  a_r4_window_mode: assert property (@(posedge clk) disable iff (rst)
    load_open |-> mode == MODE_ERASE);
  // R6: erase run request only in erase mode with window closed
  a_r6_start_state: assert property (@(posedge clk) disable iff (rst)
    erase_start |-> (mode == MODE_ERASE && !load_open));
  // R11: suspended state never entered straight from read
  a_r11_no_susp_from_read: assert property (@(posedge clk) disable iff (rst)
    (mode == MODE_SUSP) |-> ($past(mode) != MODE_READ));
  // R12: suspended-program entry comes from suspend with a request
  a_r12_sprog_entry: assert property (@(posedge clk) disable iff (rst)
    (mode == MODE_SPROG && $past(mode) != MODE_SPROG) |-> ($past(mode) == MODE_SUSP && prog_start));
  // R12: suspended program never targets a selected sector
  a_r12_prog_outside: assert property (@(posedge clk) disable iff (rst)
    (prog_start && mode == MODE_SPROG) |-> !sect_sel[prog_addr[ADDR_W-1 -: SECT_W]]);
endmodule

// File: tb/flash_cmd_decoder_bench.sv
module flash_cmd_decoder_bench;
  localparam int AW = 16, SW = 3, WIN = 4, ERS = 20, LAT = 3, PCY = 2;
  logic clk = 1'b0, rst = 1'b1;
  logic wr_en = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic prog_start, erase_start, load_open;
  logic [AW-1:0] prog_addr;
  logic [7:0] prog_data;
  logic [7:0] sect_sel;
  logic [1:0] mode;
  int total = 0, bad = 0;
  bit finished = 0;

  flash_cmd_decoder #(.ADDR_W(AW), .SECT_W(SW), .WIN_CYC(WIN), .ERASE_CYC(ERS),
    .SUSP_LAT(LAT), .PROG_CYC(PCY)) u_flash_cmd_decoder (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .prog_start(prog_start), .prog_addr(prog_addr), .prog_data(prog_data),
    .erase_start(erase_start), .sect_sel(sect_sel), .load_open(load_open), .mode(mode));

  always #4 clk = ~clk;

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [7:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic prog(input logic [AW-1:0] a, input logic [7:0] d);
    wr(16'h0555, 8'hAA); wr(16'h02AA, 8'h55); wr(16'h0555, 8'hA0); wr(a, d);
  endtask

  task automatic erase_seq(input int s);
    wr(16'h0555, 8'hAA); wr(16'h02AA, 8'h55); wr(16'h0555, 8'h80);
    wr(16'h0555, 8'hAA); wr(16'h02AA, 8'h55); wr(AW'(s) << 13, 8'h30);
  endtask

  function automatic logic [AW-1:0] sa(input int s, input int off);
    return (AW'(s) << 13) | AW'(off & 16'h1FFF);
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    idle(3);
    rst = 1'b0;
    idle(1);
    // R1 reset state
    chk("R1 mode", mode, 0); chk("R1 sel", sect_sel, 0);
    chk("R1 prog_start", prog_start, 0); chk("R1 erase_start", erase_start, 0);
    chk("R1 load_open", load_open, 0);

    // R2 program sweep across sectors
    for (int s = 0; s < 8; s++) begin
      prog(sa(s, s * 123 + 7), 8'((s * 37 + 5) & 255));
      chk("R2 prog_start", prog_start, 1);
      chk("R2 prog_addr", prog_addr, sa(s, s * 123 + 7));
      chk("R2 prog_data", prog_data, (s * 37 + 5) & 255);
      chk("R2 mode", mode, 0);
      idle(1);
      chk("R2 pulse width", prog_start, 0);
    end

    // R3 corrupt each prefix write, address or data
    for (int p = 0; p < 3; p++) begin
      for (int k = 0; k < 2; k++) begin
        logic [AW-1:0] av[4];
        logic [7:0] dv[4];
        av = '{16'h0555, 16'h02AA, 16'h0555, 16'h1234};
        dv = '{8'hAA, 8'h55, 8'hA0, 8'h5A};
        if (k == 0) av[p] = av[p] ^ 16'h0001; else dv[p] = dv[p] ^ 8'h01;
        for (int i = 0; i < 4; i++) begin
          wr(av[i], dv[i]);
          chk("R3 no request", prog_start, 0);
        end
        prog(16'h4321, 8'hC3);
        chk("R3 recovers", prog_start, 1);
      end
    end

    // R4 / R6 single-sector erase sweep
    for (int s = 0; s < 8; s++) begin
      erase_seq(s);
      chk("R4 sel", sect_sel, 1 << s); chk("R4 open", load_open, 1); chk("R4 mode", mode, 1);
      idle(WIN - 1);
      chk("R6 still open", load_open, 1); chk("R6 no start yet", erase_start, 0);
      idle(1);
      chk("R6 erase_start", erase_start, 1); chk("R6 closed", load_open, 0);
      idle(ERS - 1);
      chk("R6 erasing", mode, 1);
      idle(1);
      chk("R6 done mode", mode, 0); chk("R6 done sel", sect_sel, 0);
    end

    // R5 multi-sector load with last-edge write, duplicate, late write
    erase_seq(1);
    idle(WIN - 1);
    wr(sa(4, 9), 8'h30);
    chk("R5 last edge accepted", sect_sel, 8'h12); chk("R5 open", load_open, 1);
    idle(2);
    wr(sa(6, 0), 8'h30);
    wr(sa(4, 3), 8'h30);
    chk("R5 three sectors", sect_sel, 8'h52);
    idle(WIN);
    chk("R5 closed start", erase_start, 1);
    wr(sa(7, 0), 8'h30);
    chk("R5 late ignored", sect_sel, 8'h52); chk("R5 mode", mode, 1);
    idle(ERS - 2);
    chk("R5 erasing", mode, 1);
    idle(1);
    chk("R5 done", mode, 0);

    // R7 abort inside window
    erase_seq(1);
    idle(1);
    wr(16'h1234, 8'h55);
    chk("R7 mode", mode, 0); chk("R7 sel", sect_sel, 0); chk("R7 open", load_open, 0);
    idle(WIN + 2);
    chk("R7 stays read", mode, 0); chk("R7 no start", erase_start, 0);

    // R11 commands ignored in read
    wr(16'h0000, 8'hB0);
    chk("R11 halt ignored", mode, 0);
    wr(16'h0000, 8'h30);
    chk("R11 resume ignored", mode, 0); chk("R11 no start", erase_start, 0);

    // R8 suspend during window, then R10 resume
    erase_seq(3);
    wr(16'h0000, 8'hB0);
    chk("R8 suspended", mode, 2); chk("R8 window closed", load_open, 0);
    chk("R8 sel kept", sect_sel, 8'h08);
    idle(5);
    wr(16'h0000, 8'h30);
    chk("R10 resumed", mode, 1); chk("R10 start", erase_start, 1);
    idle(ERS - 1);
    chk("R10 full erase", mode, 1);
    idle(1);
    chk("R10 done", mode, 0);

    // R9 suspend during active erase
    erase_seq(2);
    idle(WIN);
    chk("R9 erase started", erase_start, 1);
    idle(5);
    wr(16'h0000, 8'hB0);
    chk("R9 latency", mode, 1);
    idle(LAT - 1);
    chk("R9 still erasing", mode, 1);
    idle(1);
    chk("R9 suspended", mode, 2);
    idle(10);
    chk("R9 frozen", mode, 2);
    wr(16'h0000, 8'hB0);
    chk("R11 halt in suspend", mode, 2);
    // R12 suspended program
    prog(sa(5, 16), 8'h3C);
    chk("R12 prog_start", prog_start, 1); chk("R12 addr", prog_addr, sa(5, 16));
    chk("R12 mode sprog", mode, 3);
    idle(PCY - 1);
    chk("R12 sprog hold", mode, 3);
    idle(1);
    chk("R12 back to suspend", mode, 2);
    prog(sa(2, 16), 8'h11);
    chk("R12 selected ignored", prog_start, 0); chk("R12 mode", mode, 2);
    erase_seq(6);
    chk("R12 erase ignored", sect_sel, 8'h04); chk("R12 mode kept", mode, 2);
    // R10 resume with remaining cycles
    wr(16'h0000, 8'h30);
    chk("R10 resume", mode, 1); chk("R10 resume start", erase_start, 1);
    idle(ERS - 6 - LAT - 1);
    chk("R10 remaining", mode, 1);
    idle(1);
    chk("R10 finished", mode, 0); chk("R10 sel cleared", sect_sel, 0);

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule